// File: doc/BRIEF.md
# RTC Interrupt Emulator

This block recreates the three interrupt kinds of a classic real-time clock: update-ended, alarm and periodic. It uses a fast 32-bit free-running counter and a time-of-day input. It keeps a private comparator target. Each time the counter reaches that target, the block moves the target forward by a step called delta. The size of delta depends on the requested periodic rate. If the counter has already run past several steps, the target keeps moving forward until it is ahead again, and every extra step is counted as a missed tick.

On each tick the block does three things:
- It watches the seconds input for a change (update).
- It compares hours, minutes and seconds against programmed alarm values (alarm).
- It divides the tick stream down to produce the periodic event.

When any of the three events is raised, the block publishes a flag word and pulses an interrupt strobe for one cycle.

The counter frequency is 2^CNT_LOG2 Hz (default 2^20). The polling rate used for update and alarm checks is 2^DEF_LOG2 ticks per second (default 64). The calendar counter and host software are outside this block.

Top module: `rtc_irq_emu`

## Requirements
- R1: While `upd_en`, `alm_en` and `per_en` are all low, the tick comparator is idle. In that state `tick_seen` and `irq_pulse` stay low, whatever the counter does. Dropping every enable stops a tick that is already in progress.
- R2: Raising any enable while all three were low loads the target with `cnt_now + delta`. A tick happens only once the signed 32-bit value `cnt_now - target` is zero or positive. While that value is negative, no tick occurs.
- R3: `rate_code` selects a periodic rate of 2^rate_code Hz. Values below 1 are treated as 1 and values above MAX_LOG2 (13) are treated as 13. The default delta is 2^(CNT_LOG2-6) counter cycles.
- R4: For clamped codes of 6 or less, the divide-down limit is 2^(6-code) and delta stays at the default. For codes above 6, the limit is 0, and while `per_en` is high delta becomes 2^(CNT_LOG2-code). In every other case the default delta is used.
- R5: On a tick, the target advances by delta once, then again while it is still not ahead of `cnt_now`. `missed_ticks` reports the number of advances minus one, saturating at 255. It is valid in the cycle where `tick_seen` pulses, and `tick_seen` is a single-cycle pulse.
- R6: When `per_en` is high, the missed ticks are added to the periodic tick count on each tick. While `per_en` is low, that count is held at zero.
- R7: A rising edge of `upd_en` marks the stored seconds as invalid. The next tick only records the seconds value and raises no update flag.
- R8: On a tick with `upd_en` high, the update flag is raised if `tod_sec` differs from a valid stored value. The current seconds value is then stored.
- R9: On a tick with `per_en` high, the count plus missed ticks plus one is compared with the limit. If the sum is greater than or equal to the limit, the periodic flag is raised and the count returns to zero. Otherwise the count keeps the sum.
- R10: On a tick with `alm_en` high, the alarm flag is raised when `tod_hr`, `tod_min` and `tod_sec` all equal `alm_hr`, `alm_min` and `alm_sec`.
- R11: The flag word `flags` is laid out as follows:

  | Bits | Meaning |
  |------|---------|
  | 4 | update flag |
  | 5 | alarm flag |
  | 6 | periodic flag |
  | 7 | interrupt request |
  | 15:8 | interrupt count, always 1 |
  | others | zero |

  When any flag is raised, the word is loaded and `irq_pulse` pulses for one cycle together with `tick_seen`. Otherwise the word holds its value. All outputs reset to zero.
- R12: The ahead test uses the signed difference, so scheduling works across the 2^32 wrap of the counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_now | input | 32 | Free-running counter value |
| upd_en | input | 1 | Update-ended interrupt enable |
| alm_en | input | 1 | Alarm interrupt enable |
| per_en | input | 1 | Periodic interrupt enable |
| rate_code | input | 4 | Periodic rate exponent (rate = 2^code Hz) |
| tod_sec | input | 6 | Current seconds |
| tod_min | input | 6 | Current minutes |
| tod_hr | input | 5 | Current hours |
| alm_sec | input | 6 | Alarm seconds |
| alm_min | input | 6 | Alarm minutes |
| alm_hr | input | 5 | Alarm hours |
| irq_pulse | output | 1 | One-cycle interrupt strobe |
| flags | output | 16 | Last raised flag word |
| tick_seen | output | 1 | One-cycle pulse per evaluated tick |
| missed_ticks | output | 8 | Missed ticks of the last evaluated tick |

## Verification
The assertions check the following on every cycle:
- the block stays silent while all enables are low;
- the flag word is well formed whenever the strobe fires;
- the flag word holds between strobes;
- tick pulses are single cycles;
- no update flag is raised in the tick right after the update enable rises.

Only the bench scenarios can show the arithmetic:
- the delta and limit that each rate code selects, including the clamped codes;
- the exact missed-tick count after the counter jumps;
- periodic division that carries missed ticks forward;
- alarm matching;
- scheduling across the counter wrap.

// File: rtl/rtc_emu_pkg.sv
package rtc_emu_pkg;

    typedef enum logic [1:0] {
        SCH_IDLE  = 2'd0,
        SCH_WAIT  = 2'd1,
        SCH_CATCH = 2'd2
    } sch_state_e;

    localparam int FLAG_W      = 16;
    localparam int FLG_UPD     = 4;
    localparam int FLG_ALM     = 5;
    localparam int FLG_PER     = 6;
    localparam int FLG_IRQ     = 7;
    localparam int FLG_CNT_LSB = 8;

endpackage

// File: rtl/rtc_rate_sel.sv
module rtc_rate_sel #(
    parameter int CNT_W    = 32,
    parameter int CNT_LOG2 = 20,
    parameter int DEF_LOG2 = 6,
    parameter int MAX_LOG2 = 13,
    parameter int RATE_W   = 4,
    parameter int LIM_W    = 8
) (
    input  logic [RATE_W-1:0] rate_code,
    input  logic              per_en,
    output logic [CNT_W-1:0]  delta,
    output logic [LIM_W-1:0]  limit
);

    localparam logic [CNT_W-1:0] ONE_C  = CNT_W'(1);
    localparam logic [CNT_W-1:0] DFLT_C = ONE_C << (CNT_LOG2 - DEF_LOG2);

    logic [RATE_W-1:0] code_c;
    logic [CNT_W-1:0]  per_delta;

    always_comb begin
        // clamp the requested exponent into the legal range
        code_c = rate_code;
        if (rate_code < RATE_W'(1)) begin
            code_c = RATE_W'(1);
        end else if (rate_code > RATE_W'(MAX_LOG2)) begin
            code_c = RATE_W'(MAX_LOG2);
        end

        per_delta = ONE_C << (CNT_LOG2 - int'(code_c));

        // slow rates divide the polling tick; fast rates shorten the tick
        if (code_c <= RATE_W'(DEF_LOG2)) begin
            limit = LIM_W'(1) << (DEF_LOG2 - int'(code_c));
        end else begin
            limit = '0;
        end

        delta = (per_en && (limit == '0)) ? per_delta : DFLT_C;
    end

endmodule

// File: rtl/rtc_tick_sched.sv
module rtc_tick_sched
    import rtc_emu_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int LOST_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              any_en,
    input  logic [CNT_W-1:0]  cnt_now,
    input  logic [CNT_W-1:0]  delta,
    output logic              eval,
    output logic [LOST_W-1:0] lost
);

    typedef struct packed {
        sch_state_e        state;
        logic [CNT_W-1:0]  target;
        logic [LOST_W-1:0] lost;
    } sched_t;

    sched_t s_d, s_q;
    logic [CNT_W-1:0] diff;
    logic             ahead;

    always_comb begin
        s_d   = s_q;
        eval  = 1'b0;
        diff  = cnt_now - s_q.target;
        ahead = diff[CNT_W-1];

        unique case (s_q.state)
            SCH_IDLE: begin
                if (any_en) begin
                    s_d.target = cnt_now + delta;
                    s_d.state  = SCH_WAIT;
                end
            end
            SCH_WAIT: begin
                if (!ahead) begin
                    s_d.target = s_q.target + delta;
                    s_d.lost   = '0;
                    s_d.state  = SCH_CATCH;
                end
            end
            SCH_CATCH: begin
                if (ahead) begin
                    eval      = 1'b1;
                    s_d.state = SCH_WAIT;
                end else begin
                    s_d.target = s_q.target + delta;
                    if (s_q.lost != '1) begin
                        s_d.lost = s_q.lost + LOST_W'(1);
                    end
                end
            end
            default: s_d.state = SCH_IDLE;
        endcase

        if (!any_en) begin
            s_d.state = SCH_IDLE;
            eval      = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{state: SCH_IDLE, target: '0, lost: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign lost = s_q.lost;

endmodule

// File: rtl/rtc_flag_gen.sv
module rtc_flag_gen
    import rtc_emu_pkg::*;
#(
    parameter int SEC_W  = 6,
    parameter int MIN_W  = 6,
    parameter int HR_W   = 5,
    parameter int LOST_W = 8,
    parameter int LIM_W  = 8,
    parameter int PCNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en,
    input  logic              alm_en,
    input  logic              per_en,
    input  logic              eval,
    input  logic [LOST_W-1:0] lost,
    input  logic [LIM_W-1:0]  limit,
    input  logic [SEC_W-1:0]  tod_sec,
    input  logic [MIN_W-1:0]  tod_min,
    input  logic [HR_W-1:0]   tod_hr,
    input  logic [SEC_W-1:0]  alm_sec,
    input  logic [MIN_W-1:0]  alm_min,
    input  logic [HR_W-1:0]   alm_hr,
    output logic [FLAG_W-1:0] flags,
    output logic              irq_pulse,
    output logic              tick_seen,
    output logic [LOST_W-1:0] missed
);

    localparam int PS_W = PCNT_W + 1;

    typedef struct packed {
        logic              upd_en;
        logic [SEC_W-1:0]  prev_sec;
        logic              prev_ok;
        logic [PCNT_W-1:0] pcnt;
        logic [FLAG_W-1:0] flags;
        logic              irq;
        logic              tick;
        logic [LOST_W-1:0] missed;
    } fg_t;

    fg_t f_d, f_q;
    logic            upd_rise;
    logic            uf, af, pf;
    logic [PS_W-1:0] psum;

    always_comb begin
        f_d        = f_q;
        f_d.irq    = 1'b0;
        f_d.tick   = 1'b0;
        f_d.upd_en = upd_en;
        upd_rise   = upd_en && !f_q.upd_en;
        uf         = 1'b0;
        af         = 1'b0;
        pf         = 1'b0;
        psum       = PS_W'(f_q.pcnt) + PS_W'(lost) + PS_W'(1);

        if (eval) begin
            f_d.tick   = 1'b1;
            f_d.missed = lost;

            if (upd_en && !upd_rise) begin
                uf           = f_q.prev_ok && (tod_sec != f_q.prev_sec);
                f_d.prev_sec = tod_sec;
                f_d.prev_ok  = 1'b1;
            end

            af = alm_en && (tod_hr == alm_hr) && (tod_min == alm_min)
                        && (tod_sec == alm_sec);

            if (per_en) begin
                if (psum >= PS_W'(limit)) begin
                    pf       = 1'b1;
                    f_d.pcnt = '0;
                end else begin
                    f_d.pcnt = psum[PCNT_W-1:0];
                end
            end

            if (uf || af || pf) begin
                f_d.flags                           = '0;
                f_d.flags[FLG_UPD]                  = uf;
                f_d.flags[FLG_ALM]                  = af;
                f_d.flags[FLG_PER]                  = pf;
                f_d.flags[FLG_IRQ]                  = 1'b1;
                f_d.flags[FLAG_W-1:FLG_CNT_LSB]     = (FLAG_W-FLG_CNT_LSB)'(1);
                f_d.irq                             = 1'b1;
            end
        end

        if (upd_rise) begin
            f_d.prev_ok = 1'b0;
        end
        if (!per_en) begin
            f_d.pcnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign flags     = f_q.flags;
    assign irq_pulse = f_q.irq;
    assign tick_seen = f_q.tick;
    assign missed    = f_q.missed;

endmodule

// File: rtl/rtc_irq_emu.sv
module rtc_irq_emu
    import rtc_emu_pkg::*;
#(
    parameter int CNT_LOG2 = 20,
    parameter int DEF_LOG2 = 6,
    parameter int MAX_LOG2 = 13,
    parameter int LOST_W   = 8,
    parameter int LIM_W    = 8,
    parameter int PCNT_W   = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [31:0]         cnt_now,
    input  logic                upd_en,
    input  logic                alm_en,
    input  logic                per_en,
    input  logic [3:0]          rate_code,
    input  logic [5:0]          tod_sec,
    input  logic [5:0]          tod_min,
    input  logic [4:0]          tod_hr,
    input  logic [5:0]          alm_sec,
    input  logic [5:0]          alm_min,
    input  logic [4:0]          alm_hr,
    output logic                irq_pulse,
    output logic [15:0]         flags,
    output logic                tick_seen,
    output logic [LOST_W-1:0]   missed_ticks
);

    localparam int CNT_W = 32;

    logic              any_en;
    logic [CNT_W-1:0]  delta;
    logic [LIM_W-1:0]  limit;
    logic              eval;
    logic [LOST_W-1:0] lost;

    assign any_en = upd_en || alm_en || per_en;

    rtc_rate_sel #(
        .CNT_W    (CNT_W),
        .CNT_LOG2 (CNT_LOG2),
        .DEF_LOG2 (DEF_LOG2),
        .MAX_LOG2 (MAX_LOG2),
        .RATE_W   (4),
        .LIM_W    (LIM_W)
    ) u_rate (
        .rate_code (rate_code),
        .per_en    (per_en),
        .delta     (delta),
        .limit     (limit)
    );

    rtc_tick_sched #(
        .CNT_W  (CNT_W),
        .LOST_W (LOST_W)
    ) u_sched (
        .clk     (clk),
        .rst_n   (rst_n),
        .any_en  (any_en),
        .cnt_now (cnt_now),
        .delta   (delta),
        .eval    (eval),
        .lost    (lost)
    );

    rtc_flag_gen #(
        .SEC_W  (6),
        .MIN_W  (6),
        .HR_W   (5),
        .LOST_W (LOST_W),
        .LIM_W  (LIM_W),
        .PCNT_W (PCNT_W)
    ) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_en    (upd_en),
        .alm_en    (alm_en),
        .per_en    (per_en),
        .eval      (eval),
        .lost      (lost),
        .limit     (limit),
        .tod_sec   (tod_sec),
        .tod_min   (tod_min),
        .tod_hr    (tod_hr),
        .alm_sec   (alm_sec),
        .alm_min   (alm_min),
        .alm_hr    (alm_hr),
        .flags     (flags),
        .irq_pulse (irq_pulse),
        .tick_seen (tick_seen),
        .missed    (missed_ticks)
    );

endmodule

// File: rtl/rtc_irq_emu_chk.sv
module rtc_irq_emu_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        upd_en,
    input logic        alm_en,
    input logic        per_en,
    input logic        irq_pulse,
    input logic        tick_seen,
    input logic [15:0] flags
);

    assert_quiet_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(upd_en || alm_en || per_en) |=> (!irq_pulse && !tick_seen));

    assert_irq_word_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> (flags[7] && (flags[15:8] == 8'd1) && (flags[6:4] != 3'd0)
                       && (flags[3:0] == 4'd0) && tick_seen));

    assert_flags_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_pulse |-> $stable(flags));

    assert_tick_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tick_seen |=> !tick_seen);

    assert_no_upd_after_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(upd_en) |=> !(irq_pulse && flags[4]));

endmodule

bind rtc_irq_emu rtc_irq_emu_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_en    (upd_en),
    .alm_en    (alm_en),
    .per_en    (per_en),
    .irq_pulse (irq_pulse),
    .tick_seen (tick_seen),
    .flags     (flags)
);

// File: tb/sim_rtc_irq_emu.sv
module sim_rtc_irq_emu;

    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cnt_now = '0;
    logic        upd_en = 1'b0, alm_en = 1'b0, per_en = 1'b0;
    logic [3:0]  rate_code = 4'd6;
    logic [5:0]  tod_sec = '0, tod_min = '0, alm_sec = '0, alm_min = '0;
    logic [4:0]  tod_hr = '0, alm_hr = '0;
    logic        irq_pulse, tick_seen;
    logic [15:0] flags;
    logic [7:0]  missed_ticks;

    rtc_irq_emu u0 (
        .clk(clk), .rst_n(rst_n), .cnt_now(cnt_now),
        .upd_en(upd_en), .alm_en(alm_en), .per_en(per_en), .rate_code(rate_code),
        .tod_sec(tod_sec), .tod_min(tod_min), .tod_hr(tod_hr),
        .alm_sec(alm_sec), .alm_min(alm_min), .alm_hr(alm_hr),
        .irq_pulse(irq_pulse), .flags(flags), .tick_seen(tick_seen),
        .missed_ticks(missed_ticks)
    );

    always #(CLK_NS/2) clk = ~clk;

    int nchk = 0;
    int nbad = 0;
    int cyc  = 0;

    // bench model state
    logic [31:0] tgt = '0;
    int          pcnt = 0;
    logic [5:0]  psec = '0;
    bit          pok = 1'b0;
    logic [15:0] eflags = '0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            nbad = nbad + 1;
            $display("FAIL watchdog: run hung act=%0d exp<150000", cyc);
            $display("test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end

    function automatic int m_code(int k);
        if (k < 1) return 1;
        if (k > 13) return 13;
        return k;
    endfunction

    function automatic int m_limit(int k);
        int c = m_code(k);
        return (c <= 6) ? (1 << (6 - c)) : 0;
    endfunction

    function automatic logic [31:0] m_delta(int k, bit p);
        int c = m_code(k);
        if (p && m_limit(k) == 0) return 32'd1 << (20 - c);
        return 32'd1 << 14;
    endfunction

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        nchk = nchk + 1;
        if (!ok) begin
            nbad = nbad + 1;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic set_en(bit u, bit a, bit p);
        bit was_off = !(upd_en || alm_en || per_en);
        if (u && !upd_en) pok = 1'b0;
        if (!p) pcnt = 0;
        if (was_off && (u || a || p)) tgt = cnt_now + m_delta(int'(rate_code), p);
        upd_en = u; alm_en = a; per_en = p;
        step(); step();
    endtask

    task automatic no_tick(int n, string req);
        bit seen = 1'b0;
        for (int i = 0; i < n; i++) begin
            step();
            if (tick_seen) seen = 1'b1;
        end
        check(!seen, req, "unexpected tick", seen, 0);
    endtask

    task automatic fire(logic [31:0] c1, string req);
        logic [31:0] d, diff;
        int unsigned n, lost;
        bit got, uf, af, pf;
        d = m_delta(int'(rate_code), per_en);
        cnt_now = c1;
        diff = c1 - tgt;
        if (diff[31]) begin
            no_tick(8, req);
            return;
        end
        n = diff / d + 1;
        lost = n - 1;
        tgt = tgt + n * d;
        got = 1'b0;
        for (int i = 0; i < int'(n) + 10; i++) begin
            step();
            if (tick_seen) begin got = 1'b1; break; end
        end
        check(got, req, "tick missing", got, 1);
        uf = 1'b0; af = 1'b0; pf = 1'b0;
        if (upd_en) begin
            uf = pok && (tod_sec != psec);
            psec = tod_sec; pok = 1'b1;
        end
        af = alm_en && tod_sec == alm_sec && tod_min == alm_min && tod_hr == alm_hr;
        if (per_en) begin
            pcnt = pcnt + int'(lost) + 1;
            if (pcnt >= m_limit(int'(rate_code))) begin pf = 1'b1; pcnt = 0; end
        end
        if (uf || af || pf)
            eflags = 16'h0180 | (16'(uf) << 4) | (16'(af) << 5) | (16'(pf) << 6);
        check(missed_ticks == 8'((lost > 255) ? 255 : lost), req, "missed_ticks",
              missed_ticks, lost);
        check(irq_pulse == (uf || af || pf), req, "irq_pulse", irq_pulse, uf || af || pf);
        check(flags == eflags, req, "flags", flags, eflags);
    endtask

    initial begin
        int unsigned seed = 32'd4321;
        void'($urandom(seed));
        repeat (3) step();
        // reset state (R11)
        check(flags == 16'h0 && !irq_pulse && !tick_seen && missed_ticks == 8'h0,
              "R11", "reset outputs", flags, 0);
        rst_n = 1'b1;
        step();

        // R1: all enables off, counter jumps, nothing happens
        cnt_now = 32'h1000_0000;
        no_tick(20, "R1");
        cnt_now = 32'h0;
        step();

        // update path, rate 64
        rate_code = 4'd6;
        tod_sec = 6'd10; alm_hr = 5'd23; alm_min = 6'd59; alm_sec = 6'd59;
        set_en(1, 0, 0);
        fire(32'd16383, "R2");            // one below target: no tick
        fire(32'd16384, "R7");            // first tick after enable: record only
        tod_sec = 6'd11;
        fire(tgt, "R8");                  // seconds changed: update flag
        fire(tgt + 2 * m_delta(6, 0), "R5"); // two missed ticks, no flag
        // alarm
        alm_hr = 5'd0; alm_min = 6'd0; alm_sec = 6'd11;
        set_en(1, 1, 0);
        fire(tgt, "R10");

        // periodic divide-down, rate 16 => limit 4
        set_en(0, 0, 0);
        rate_code = 4'd4;
        set_en(0, 0, 1);
        for (int i = 0; i < 4; i++) fire(tgt, "R9");
        fire(tgt + 2 * m_delta(4, 1), "R6"); // 3 counts at once
        fire(tgt, "R9");

        // fast periodic, rate 1024 => delta 1024
        set_en(0, 0, 0);
        rate_code = 4'd10;
        set_en(0, 0, 1);
        fire(tgt + 32'd1023, "R4");
        fire(tgt + 5 * 32'd1024, "R4");

        // clamp above range: code 15 acts as 13 (delta 128)
        set_en(0, 0, 0);
        rate_code = 4'd15;
        set_en(0, 0, 1);
        fire(tgt + 3 * 32'd128, "R3");
        // clamp below: code 0 acts as 1 (limit 32)
        set_en(0, 0, 0);
        rate_code = 4'd0;
        set_en(0, 0, 1);
        fire(tgt + 30 * m_delta(0, 1), "R3");  // 31 counts: below limit
        fire(tgt, "R3");                       // 32nd: periodic flag

        // counter wrap
        set_en(0, 0, 0);
        rate_code = 4'd10;
        cnt_now = 32'hFFFF_F000;
        step();
        set_en(1, 0, 1);
        fire(32'hFFFF_F3FF, "R12");
        fire(32'h0000_0100, "R12");

        // disable mid-flight stops ticks
        set_en(0, 0, 0);
        cnt_now = tgt + 32'h0010_0000;
        no_tick(20, "R1");

        // random sessions
        for (int s = 0; s < 8; s++) begin
            set_en(0, 0, 0);
            rate_code = 4'($urandom % 16);
            alm_hr = 5'd0; alm_min = 6'd0; alm_sec = 6'd1;
            tod_hr = 5'd0; tod_min = 6'd0;
            begin
                int e = 1 + int'($urandom % 7);
                set_en(e[0], e[1], e[2]);
            end
            for (int i = 0; i < 12; i++) begin
                logic [31:0] d = m_delta(int'(rate_code), per_en);
                tod_sec = 6'($urandom % 3);
                if ($urandom % 5 == 0) fire(tgt - 1 - ($urandom % 100), "R2");
                else                   fire(tgt + ($urandom % (3 * d)), "R5");
            end
        end

        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

endmodule